// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a multi-channel event timer. A free-running main counter is shared by all channels and comes in from outside. The channel compares that counter with its own comparator and sends a single-cycle event to the interrupt logic when the counter reaches the target. In one-shot mode it fires once per arming. In periodic mode it reloads itself by adding a hidden period register. A 32-bit mode narrows both the storage and the comparison to the low half of the counter.

Software reaches the channel through three write strobes that share one 32-bit data bus: a configuration word, the low comparator half and the high comparator half. The configuration and the comparator can be read back on output buses. Bus decoding, interrupt routing and the counter itself belong to the surrounding timer block.

Configuration low-word layout:
- bit 0: arm
- bit 1: periodic
- bit 2: set-value
- bit 3: 32-bit mode
- bits 5:4: read-only capability flags, periodic-capable and 64-bit-capable, both reading 1

All other bits read 0, except bits 63:32, which read as the constant 0x4.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones, the configuration reads 0x0000_0004_0000_0030, and neither `match_o` nor `drop_o` is asserted.
- R2: A configuration write changes only bits 3:0. Every other bit of the 64-bit configuration keeps its fixed value, whatever the written data.
- R3: Writing the configuration with bit 3 set clears the upper 32 bits of the comparator and of the period. From then on, matching uses only the low 32 bits of the counter and the comparator.
- R4: In one-shot mode, `match_o` is high for exactly one cycle. It goes high in the cycle after the first cycle in which the counter has reached or passed the comparator (signed difference comparator − counter ≤ 0). It does not repeat while the counter stays past the comparator.
- R5: In periodic mode, a comparator write (either half) always updates the period. It updates the comparator as well only when set-value (bit 2) is 1. Set-value clears itself after any comparator write.
- R6: The stored period always has its top bit cleared. That is bit 31 for a low-half write in 32-bit mode, and bit 63 for a high-half write in 64-bit mode.
- R7: In periodic mode with a nonzero period, each event adds the period to the comparator, so events recur every period ticks.
- R8: If the counter has moved several periods past the comparator, the channel adds the period, one addition per cycle, until the comparator is ahead. It raises a single event for the whole catch-up.
- R9: In one-shot 32-bit mode, the channel raises one extra event on the cycle after the counter's low 32 bits equal 0xFFFFFFFF, provided the comparator match has not yet occurred since arming. In 64-bit mode no such event occurs.
- R10: Setting arm while the counter is already past the comparator produces an event. Clearing arm pulses `drop_o` for one cycle, and no further events follow.
- R11: While the global enable is low, no events are produced. Raising it while the counter is past the comparator produces one event.
- R12: In 32-bit mode, a high-half comparator write changes neither the comparator nor the period, but it still clears set-value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 64 | Shared main counter value |
| glb_en_i | input | 1 | Global enable of the timer block |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cmp_lo_wr_i | input | 1 | Comparator low-half write strobe |
| cmp_hi_wr_i | input | 1 | Comparator high-half write strobe |
| wdata_i | input | 32 | Write data shared by the three strobes |
| cfg_o | output | 64 | Configuration readback |
| cmp_o | output | 64 | Comparator readback |
| match_o | output | 1 | One-cycle match event to interrupt logic |
| drop_o | output | 1 | One-cycle request to withdraw a pending interrupt on disarm |

## Verification
The bench steps the counter across the comparator and counts events. A design using plain equality, or rising-edge-only detection, either misses the catch-up case or merges consecutive periods. It jumps the counter several periods ahead; a design that fires once per addition would emit a burst, and one that adds only once would leave the comparator behind. It writes the period with top bits set in both widths, and a missing mask shows up in the reloaded comparator. It runs a one-shot 32-bit timer across a wrap, where a missing wrap event or a repeated one changes the event count. It feeds counter values whose upper half disagrees with the low half, so a design comparing all 64 bits in 32-bit mode stays silent.

// File: rtl/evt_pkg.sv
package evt_pkg;

    // Writable configuration bit positions
    localparam int CFG_ARM    = 0;
    localparam int CFG_PER    = 1;
    localparam int CFG_SETV   = 2;
    localparam int CFG_M32    = 3;
    localparam int CFG_WBITS  = 4;

    // Writable configuration state
    typedef struct packed {
        logic mode32;
        logic setval;
        logic periodic;
        logic arm;
    } cfg_state_t;

    // Match detector state
    typedef struct packed {
        logic live;
        logic catchup;
        logic wrap_pend;
        logic glb;
        logic ev;
        logic drop;
    } match_state_t;

endpackage

// File: rtl/evt_cfg_reg.sv
module evt_cfg_reg
    import evt_pkg::*;
#(
    parameter int CW = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [CFG_WBITS-1:0] wdata_i,
    input  logic                 cmp_wr_i,
    output logic [CW-1:0]        cfg_o,
    output logic                 arm_o,
    output logic                 periodic_o,
    output logic                 setval_o,
    output logic                 mode32_o,
    output logic                 arm_rise_o,
    output logic                 arm_fall_o,
    output logic                 trunc_o
);
    localparam int HW = CW / 2;

    cfg_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        arm_rise_o = wr_i &&  wdata_i[CFG_ARM] && !s_q.arm;
        arm_fall_o = wr_i && !wdata_i[CFG_ARM] &&  s_q.arm;
        trunc_o    = wr_i &&  wdata_i[CFG_M32];
        if (wr_i) begin
            s_d.arm      = wdata_i[CFG_ARM];
            s_d.periodic = wdata_i[CFG_PER];
            s_d.setval   = wdata_i[CFG_SETV];
            s_d.mode32   = wdata_i[CFG_M32];
        end
        if (cmp_wr_i) begin
            s_d.setval = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign arm_o      = s_q.arm;
    assign periodic_o = s_q.periodic;
    assign setval_o   = s_q.setval;
    assign mode32_o   = s_q.mode32;

    // Upper half: allowed-line flag 0x4; lower half: capabilities and writable bits
    assign cfg_o = { {(HW-3){1'b0}}, 3'b100,
                     {(HW-6){1'b0}}, 2'b11,
                     s_q.mode32, s_q.setval, s_q.periodic, s_q.arm };

    assert_setval_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr_i |=> !setval_o);

    assert_arm_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arm_rise_o |=> arm_o);

endmodule

// File: rtl/evt_cmp_store.sv
module evt_cmp_store #(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lo_wr_i,
    input  logic          hi_wr_i,
    input  logic [CW/2-1:0] wdata_i,
    input  logic          periodic_i,
    input  logic          setval_i,
    input  logic          mode32_i,
    input  logic          trunc_i,
    input  logic          reload_i,
    input  logic [CW-1:0] reload_val_i,
    output logic [CW-1:0] cmp_o,
    output logic [CW-1:0] per_o
);
    localparam int HW = CW / 2;
    localparam logic [HW-1:0] TOP_CLR = {1'b0, {(HW-1){1'b1}}};

    typedef struct packed {
        logic [CW-1:0] cmp;
        logic [CW-1:0] per;
    } store_t;

    store_t s_d, s_q;
    logic   cmp_take;

    always_comb begin
        s_d      = s_q;
        cmp_take = !periodic_i || setval_i;
        if (trunc_i) begin
            s_d.cmp[CW-1:HW]   = '0;
            s_d.per[CW-1:HW-1] = '0;
        end else if (lo_wr_i) begin
            if (cmp_take) begin
                s_d.cmp[HW-1:0] = wdata_i;
            end
            if (periodic_i) begin
                s_d.per[HW-1:0] = mode32_i ? (wdata_i & TOP_CLR) : wdata_i;
            end
        end else if (hi_wr_i) begin
            if (!mode32_i) begin
                if (cmp_take) begin
                    s_d.cmp[CW-1:HW] = wdata_i;
                end
                if (periodic_i) begin
                    s_d.per[CW-1:HW] = wdata_i & TOP_CLR;
                end
            end
        end else if (reload_i) begin
            s_d.cmp = reload_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cmp <= '1;
            s_q.per <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmp_o = s_q.cmp;
    assign per_o = s_q.per;

    assert_per_top_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        per_o[CW-1] == 1'b0);

    assert_narrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode32_i |-> (cmp_o[CW-1:HW] == '0 && per_o[CW-1:HW-1] == '0));

    assert_cmp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_wr_i || hi_wr_i || trunc_i || reload_i) |=> $stable(cmp_o));

endmodule

// File: rtl/evt_match.sv
module evt_match
    import evt_pkg::*;
#(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] cmp_i,
    input  logic [CW-1:0] per_i,
    input  logic          glb_en_i,
    input  logic          arm_i,
    input  logic          periodic_i,
    input  logic          mode32_i,
    input  logic          arm_rise_i,
    input  logic          arm_fall_i,
    input  logic          cmp_wr_i,
    output logic          reload_o,
    output logic [CW-1:0] reload_val_o,
    output logic          match_o,
    output logic          drop_o
);
    localparam int HW = CW / 2;

    match_state_t  s_d, s_q;
    logic [CW-1:0] diff, sum, sdiff;
    logic [HW-1:0] lo_sum;
    logic          live, per_ok, hit, wrap_hit, sum_ahead;

    // Counter at or past target in signed-difference terms
    function automatic logic reached_f(input logic [CW-1:0] d, input logic m32);
        if (m32) begin
            reached_f = (d[HW-1:0] == '0) || d[HW-1];
        end else begin
            reached_f = (d == '0) || d[CW-1];
        end
    endfunction

    always_comb begin
        s_d       = s_q;
        diff      = cmp_i - cnt_i;
        live      = arm_i && glb_en_i && reached_f(diff, mode32_i);
        per_ok    = periodic_i && (per_i != '0);
        lo_sum    = cmp_i[HW-1:0] + per_i[HW-1:0];
        sum       = mode32_i ? { {HW{1'b0}}, lo_sum } : (cmp_i + per_i);
        sdiff     = sum - cnt_i;
        sum_ahead = !reached_f(sdiff, mode32_i);
        reload_o  = per_ok && live;
        hit       = per_ok ? (live && !s_q.catchup) : (live && !s_q.live);
        wrap_hit  = s_q.wrap_pend && arm_i && glb_en_i && mode32_i && !periodic_i
                    && (cnt_i[HW-1:0] == '1);

        s_d.live    = live;
        s_d.catchup = reload_o && !sum_ahead && !cmp_wr_i;
        s_d.glb     = glb_en_i;
        s_d.ev      = hit || wrap_hit;
        s_d.drop    = arm_fall_i;
        if (hit || wrap_hit) begin
            s_d.wrap_pend = 1'b0;
        end
        if (arm_rise_i || cmp_wr_i || (glb_en_i && !s_q.glb)) begin
            s_d.wrap_pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign reload_val_o = sum;
    assign match_o      = s_q.ev;
    assign drop_o       = s_q.drop;

    assert_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i || !glb_en_i) |=> !match_o);

    assert_drop_on_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arm_i) |-> drop_o);

    assert_catchup_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.catchup && per_ok) |=> !match_o);

endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
    import evt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic               glb_en_i,
    input  logic               cfg_wr_i,
    input  logic               cmp_lo_wr_i,
    input  logic               cmp_hi_wr_i,
    input  logic [CNT_W/2-1:0] wdata_i,
    output logic [CNT_W-1:0]   cfg_o,
    output logic [CNT_W-1:0]   cmp_o,
    output logic               match_o,
    output logic               drop_o
);
    logic             cmp_wr;
    logic             arm, periodic, setval, mode32;
    logic             arm_rise, arm_fall, trunc;
    logic             reload;
    logic [CNT_W-1:0] reload_val, per;

    assign cmp_wr = cmp_lo_wr_i || cmp_hi_wr_i;

    evt_cfg_reg #(.CW(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (cfg_wr_i),
        .wdata_i    (wdata_i[CFG_WBITS-1:0]),
        .cmp_wr_i   (cmp_wr),
        .cfg_o      (cfg_o),
        .arm_o      (arm),
        .periodic_o (periodic),
        .setval_o   (setval),
        .mode32_o   (mode32),
        .arm_rise_o (arm_rise),
        .arm_fall_o (arm_fall),
        .trunc_o    (trunc)
    );

    evt_cmp_store #(.CW(CNT_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .lo_wr_i      (cmp_lo_wr_i),
        .hi_wr_i      (cmp_hi_wr_i),
        .wdata_i      (wdata_i),
        .periodic_i   (periodic),
        .setval_i     (setval),
        .mode32_i     (mode32),
        .trunc_i      (trunc),
        .reload_i     (reload),
        .reload_val_i (reload_val),
        .cmp_o        (cmp_o),
        .per_o        (per)
    );

    evt_match #(.CW(CNT_W)) u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_i        (cnt_i),
        .cmp_i        (cmp_o),
        .per_i        (per),
        .glb_en_i     (glb_en_i),
        .arm_i        (arm),
        .periodic_i   (periodic),
        .mode32_i     (mode32),
        .arm_rise_i   (arm_rise),
        .arm_fall_i   (arm_fall),
        .cmp_wr_i     (cmp_wr),
        .reload_o     (reload),
        .reload_val_o (reload_val),
        .match_o      (match_o),
        .drop_o       (drop_o)
    );

endmodule

// File: tb/evt_cmp_channel_tb.sv
module evt_cmp_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] cnt;
    logic        glb;
    logic        cfg_wr, lo_wr, hi_wr;
    logic [31:0] wdata;
    logic [63:0] cfg_o, cmp_o;
    logic        match_o, drop_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    evt_cmp_channel u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_i       (cnt),
        .glb_en_i    (glb),
        .cfg_wr_i    (cfg_wr),
        .cmp_lo_wr_i (lo_wr),
        .cmp_hi_wr_i (hi_wr),
        .wdata_i     (wdata),
        .cfg_o       (cfg_o),
        .cmp_o       (cmp_o),
        .match_o     (match_o),
        .drop_o      (drop_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_cfg(input logic [31:0] v);
        cfg_wr = 1'b1; wdata = v; tick(); cfg_wr = 1'b0;
    endtask

    task automatic wr_lo(input logic [31:0] v);
        lo_wr = 1'b1; wdata = v; tick(); lo_wr = 1'b0;
    endtask

    task automatic wr_hi(input logic [31:0] v);
        hi_wr = 1'b1; wdata = v; tick(); hi_wr = 1'b0;
    endtask

    task automatic run_cnt(input logic [63:0] start, input int n,
                           output int evs, output logic [63:0] first_at);
        evs = 0;
        first_at = '0;
        for (int i = 0; i < n; i++) begin
            cnt = start + 64'(i);
            tick();
            if (match_o) begin
                if (evs == 0) first_at = cnt;
                evs++;
            end
        end
    endtask

    task automatic t_reset();
        chk("R1 cfg", cfg_o, 64'h0000_0004_0000_0030);
        chk("R1 cmp", cmp_o, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R1 match", 64'(match_o), 64'd0);
        chk("R1 drop", 64'(drop_o), 64'd0);
    endtask

    task automatic t_cfg_mask();
        wr_cfg(32'hFFFF_FFF0);
        chk("R2 read-only bits", cfg_o, 64'h0000_0004_0000_0030);
        wr_cfg(32'h0000_0006);
        chk("R2 writable bits", cfg_o, 64'h0000_0004_0000_0036);
        wr_cfg(32'h0);
    endtask

    task automatic t_oneshot_and_gate();
        int evs; logic [63:0] at;
        glb = 1'b1; cnt = 64'd0;
        wr_lo(32'd100);
        wr_hi(32'd0);
        chk("R4 cmp written", cmp_o, 64'd100);
        wr_cfg(32'h1);
        run_cnt(64'd95, 16, evs, at);
        chk("R4 one event", 64'(evs), 64'd1);
        chk("R4 event at match", at, 64'd100);
        glb = 1'b0; cnt = 64'd0; tick();
        run_cnt(64'd100, 6, evs, at);
        chk("R11 silent while disabled", 64'(evs), 64'd0);
        glb = 1'b1;
        run_cnt(64'd105, 1, evs, at);
        begin
            int more; logic [63:0] a2;
            run_cnt(64'd105, 3, more, a2);
            chk("R11 one event on enable", 64'(evs + more), 64'd1);
        end
    endtask

    task automatic t_arm_edges();
        int evs; logic [63:0] at;
        wr_cfg(32'h0);
        chk("R10 drop pulse", 64'(drop_o), 64'd1);
        tick();
        chk("R10 drop one cycle", 64'(drop_o), 64'd0);
        cnt = 64'd50; tick();
        run_cnt(64'd100, 4, evs, at);
        chk("R10 no events when disarmed", 64'(evs), 64'd0);
        cnt = 64'd200;
        wr_cfg(32'h1);
        chk("R10 not yet", 64'(match_o), 64'd0);
        tick();
        chk("R10 arm while past", 64'(match_o), 64'd1);
        wr_cfg(32'h0);
    endtask

    task automatic t_periodic();
        int evs; logic [63:0] at;
        wr_cfg(32'h6);
        wr_lo(32'd1000);
        wr_hi(32'd0);
        chk("R5 cmp via set-value", cmp_o, 64'd1000);
        chk("R5 set-value cleared", 64'(cfg_o[2]), 64'd0);
        wr_lo(32'd50);
        chk("R5 cmp kept without set-value", cmp_o, 64'd1000);
        cnt = 64'd990;
        wr_cfg(32'h3);
        run_cnt(64'd991, 130, evs, at);
        chk("R7 events each period", 64'(evs), 64'd3);
        chk("R7 comparator advanced", cmp_o, 64'd1150);
    endtask

    task automatic t_skip();
        int evs = 0;
        cnt = 64'd1500;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (match_o) evs++;
        end
        chk("R8 single event on skip", 64'(evs), 64'd1);
        chk("R8 comparator ahead", cmp_o, 64'd1550);
    endtask

    task automatic t_period_mask_and_narrow();
        wr_cfg(32'h6);
        wr_lo(32'd10);
        wr_hi(32'hFFFF_FFFF);
        cnt = 64'd5;
        wr_cfg(32'h3);
        cnt = 64'd10; tick();
        chk("R7 event at 10", 64'(match_o), 64'd1);
        chk("R6 top bit 63 masked", cmp_o, 64'h7FFF_FFFF_0000_0014);
        wr_cfg(32'hE);
        chk("R3 truncated", cmp_o, 64'h0000_0000_0000_0014);
        wr_lo(32'hFFFF_FFF0);
        cnt = 64'hF000_0000_FFFF_FFE0;
        wr_cfg(32'hB);
        cnt = 64'hF000_0000_FFFF_FFF0; tick();
        chk("R3 low-half match", 64'(match_o), 64'd1);
        chk("R6 top bit 31 masked", cmp_o, 64'h0000_0000_7FFF_FFE0);
        wr_cfg(32'hE);
        wr_hi(32'h55);
        chk("R12 high write ignored", cmp_o, 64'h0000_0000_7FFF_FFE0);
        chk("R12 set-value cleared", 64'(cfg_o[2]), 64'd0);
    endtask

    task automatic t_wrap();
        int evs; logic [63:0] at;
        wr_cfg(32'h8);
        wr_lo(32'h20);
        cnt = 64'h0000_0000_FFFF_FFF0;
        wr_cfg(32'h9);
        run_cnt(64'h0000_0000_FFFF_FFF1, 56, evs, at);
        chk("R9 wrap plus match", 64'(evs), 64'd2);
        chk("R9 first at wrap", at, 64'h0000_0000_FFFF_FFFF);
        wr_cfg(32'h0);
        wr_lo(32'h20);
        wr_hi(32'h1);
        cnt = 64'h0000_0000_FFFF_FFF0;
        wr_cfg(32'h1);
        run_cnt(64'h0000_0000_FFFF_FFF1, 56, evs, at);
        chk("R9 no wrap event in 64-bit", 64'(evs), 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cnt = '0; glb = 1'b0;
        cfg_wr = 1'b0; lo_wr = 1'b0; hi_wr = 1'b0; wdata = '0;
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_cfg_mask();
        t_oneshot_and_gate();
        t_arm_edges();
        t_periodic();
        t_skip();
        t_period_mask_and_narrow();
        t_wrap();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule